// File: doc/BRIEF.md
# Cartridge Bank-Select Controller

This block holds the banking state of a plug-in ROM/flash cartridge for an 8-bit home computer. The host selects one of up to 128 banks of 8 kB by writing to a small I/O page at `$D500`–`$D5FF`. The bank number is carried by the low bits of the write address; no data bus enters the block. Writing to page offset `$80` turns the cartridge off. Any later write to an offset from `$00` to `$7F` loads that bank and turns it back on.

Accesses to the 8 kB memory window at `$A000`–`$BFFF` are routed to one of two memory sockets. Banks 0–63 live in the first socket and banks 64–127 in the second. The block drives the in-socket address, one chip select per socket, and one gated write enable per socket so that flash programming cycles reach the selected chip. A strap input can write-protect the first socket, so that it behaves as ROM. Each socket can be given a device size smaller than its share of the bank space. The bank bits above that size are then dropped, and bank contents repeat.

Top module: `cart_bank`

## Requirements
- R1: After reset, bank 0 is selected and the cartridge is enabled (`cartAbsent` low), so a window access selects socket 0 with in-socket address `{6'd0, busAddr[12:0]}`.
- R2: A write with `busAddr[15:8]` = `$D5` and `busAddr[7]` = 0 selects bank `busAddr[6:0]` from the next clock edge on.
- R3: A write to `$D580` disables the cartridge from the next edge on: `cartAbsent` is high and neither chip select asserts, whatever the access.
- R4: A write to any offset `$00`–`$7F` while disabled re-enables the cartridge with the addressed bank.
- R5: `chipSel[0]` asserts only for banks 0–63 and `chipSel[1]` only for banks 64–127. Either asserts only while `busValid` is high and `busAddr[15:13]` = `3'b101`. At most one is high.
- R6: `memAddr` is `{bank[5:0], busAddr[12:0]}`, with bank bits at or above the socket's device-size parameter forced to 0, so that aliased banks give the same address.
- R7: `chipWe[s]` is high only when `chipSel[s]` is high and `busWrite` is high. `chipWe[0]` is held low while `wrProtect` is high. `chipWe[1]` ignores `wrProtect`.
- R8: Writes to page offsets `$81`–`$FF`, reads of the `$D5` page and writes outside that page leave the bank and the enable state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Host bus cycle in progress |
| busWrite | input | 1 | Cycle is a write (1) or read (0) |
| busAddr | input | 16 | Host address |
| wrProtect | input | 1 | Write-protect strap for socket 0 |
| memAddr | output | 19 | In-socket memory address |
| chipSel | output | 2 | Chip select per socket, active high |
| chipWe | output | 2 | Write enable per socket, active high |
| cartAbsent | output | 1 | Cartridge turned off |

## Verification
Bank loads are tried at both ends of each socket (0, 63, 64, 127) and at values in between, so a wrong socket split or a truncated bank field shows up. The bench is built with a smaller device in socket 1, so banks 96 and 64 must give the same address, which tests the size masking. Disable, re-enable, the unused offsets above `$80`, page reads and writes to a neighbouring page separate real register loads from stray ones. Window writes with the strap high and low, in each socket, show that protection applies to the first chip only.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  // Strobes from the bus decoder to the bank datapath
  typedef struct packed {
    logic       loadBank;   // I/O page write, offset below $80
    logic       turnOff;    // I/O page write, offset exactly $80
    logic [7:0] offset;     // page offset carried by the address
    logic       winAccess;  // valid cycle inside the memory window
    logic       winWrite;   // that cycle is a write
  } ctrlStrobe_t;
endpackage

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          WIN_BITS = 13,
  parameter logic [7:0]  IO_PAGE  = 8'hD5,
  parameter logic [15:0] WIN_BASE = 16'hA000
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  logic pageWrite;
  logic [7:0] pageOff;

  always_comb begin
    pageOff   = busAddr[7:0];
    pageWrite = busValid && busWrite && (busAddr[ADDR_W-1:8] == IO_PAGE);
    strobe.loadBank  = pageWrite && !pageOff[7];
    strobe.turnOff   = pageWrite && (pageOff == 8'h80);
    strobe.offset    = pageOff;
    strobe.winAccess = busValid &&
                       (busAddr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1 -: HI_W]);
    strobe.winWrite  = busWrite;
  end
endmodule

// File: rtl/cart_bank_dpath.sv
module cart_bank_dpath
  import cart_bank_pkg::*;
#(
  parameter int BANK_BITS     = 7,
  parameter int WIN_BITS      = 13,
  parameter int SPLIT_BIT     = 6,
  parameter int DEV0_BANK_BITS = 6,
  parameter int DEV1_BANK_BITS = 6,
  localparam int SOCK_BITS = (BANK_BITS > SPLIT_BIT) ? SPLIT_BIT : BANK_BITS,
  localparam int MEM_W     = SOCK_BITS + WIN_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [WIN_BITS-1:0] winOff,
  input  logic                wrProtect,
  output logic [MEM_W-1:0]    memAddr,
  output logic [1:0]          chipSel,
  output logic [1:0]          chipWe,
  output logic                cartAbsent
);
  localparam logic [SOCK_BITS-1:0] MASK0 =
    SOCK_BITS'((64'd1 << DEV0_BANK_BITS) - 64'd1);
  localparam logic [SOCK_BITS-1:0] MASK1 =
    SOCK_BITS'((64'd1 << DEV1_BANK_BITS) - 64'd1);

  logic [BANK_BITS-1:0] bankReg;
  logic                 cartOn;
  logic                 upperSock;
  logic [SOCK_BITS-1:0] sockBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg <= '0;
      cartOn  <= 1'b1;
    end else if (strobe.turnOff) begin
      cartOn  <= 1'b0;
    end else if (strobe.loadBank) begin
      bankReg <= strobe.offset[BANK_BITS-1:0];
      cartOn  <= 1'b1;
    end
  end

  generate
    if (BANK_BITS > SPLIT_BIT) begin : g_twoSock
      assign upperSock = bankReg[SPLIT_BIT];
    end else begin : g_oneSock
      assign upperSock = 1'b0;
    end
  endgenerate

  always_comb begin
    sockBank   = bankReg[SOCK_BITS-1:0] & (upperSock ? MASK1 : MASK0);
    memAddr    = {sockBank, winOff};
    chipSel[0] = strobe.winAccess && cartOn && !upperSock;
    chipSel[1] = strobe.winAccess && cartOn && upperSock;
    chipWe[0]  = chipSel[0] && strobe.winWrite && !wrProtect;
    chipWe[1]  = chipSel[1] && strobe.winWrite;
    cartAbsent = !cartOn;
  end
endmodule

// File: rtl/cart_bank.sv
module cart_bank
  import cart_bank_pkg::*;
#(
  parameter int BANK_BITS      = 7,
  parameter int DEV0_BANK_BITS = 6,
  parameter int DEV1_BANK_BITS = 6,
  localparam int ADDR_W    = 16,
  localparam int WIN_BITS  = 13,
  localparam int SPLIT_BIT = 6,
  localparam int SOCK_BITS = (BANK_BITS > SPLIT_BIT) ? SPLIT_BIT : BANK_BITS,
  localparam int MEM_W     = SOCK_BITS + WIN_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrProtect,
  output logic [MEM_W-1:0]  memAddr,
  output logic [1:0]        chipSel,
  output logic [1:0]        chipWe,
  output logic              cartAbsent
);
  ctrlStrobe_t strobe;

  cart_bank_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
  ) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .strobe(strobe)
  );

  cart_bank_dpath #(
    .BANK_BITS(BANK_BITS), .WIN_BITS(WIN_BITS), .SPLIT_BIT(SPLIT_BIT),
    .DEV0_BANK_BITS(DEV0_BANK_BITS), .DEV1_BANK_BITS(DEV1_BANK_BITS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .winOff(busAddr[WIN_BITS-1:0]), .wrProtect(wrProtect),
    .memAddr(memAddr), .chipSel(chipSel), .chipWe(chipWe),
    .cartAbsent(cartAbsent)
  );
endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk #(
  parameter int MEM_W = 19
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic             busWrite,
  input logic [15:0]      busAddr,
  input logic             wrProtect,
  input logic [MEM_W-1:0] memAddr,
  input logic [1:0]       chipSel,
  input logic [1:0]       chipWe,
  input logic             cartAbsent
);
  logic pageCyc;
  assign pageCyc = busValid && (busAddr[15:8] == 8'hD5);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chipSel)); // R5
  AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel != 2'b00) |-> (busValid && busAddr[15:13] == 3'b101)); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cartAbsent |-> (chipSel == 2'b00)); // R3
  AST_OFF_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (pageCyc && busWrite && busAddr[7:0] == 8'h80) |=> cartAbsent); // R3
  AST_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (pageCyc && busWrite && !busAddr[7]) |=> !cartAbsent); // R4
  AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    ((chipWe & ~chipSel) == 2'b00) && (chipWe == 2'b00 || busWrite)); // R7
  AST_PROTECT: assert property (@(posedge clk) disable iff (!rstN)
    wrProtect |-> !chipWe[0]); // R7
  AST_PAGE_READ_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (pageCyc && !busWrite) |=> $stable(cartAbsent)); // R8
endmodule

bind cart_bank cart_bank_chk #(.MEM_W(MEM_W)) u_chk (.*);

// File: tb/test_cart_bank.sv
module test_cart_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DEV1 = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        wrProtect = 1'b0;
  logic [18:0] memAddr;
  logic [1:0]  chipSel;
  logic [1:0]  chipWe;
  logic        cartAbsent;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cart_bank #(.DEV1_BANK_BITS(DEV1)) i_cart_bank (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .wrProtect(wrProtect), .memAddr(memAddr),
    .chipSel(chipSel), .chipWe(chipWe), .cartAbsent(cartAbsent)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [18:0] expMem(int bank, logic [15:0] a);
    logic [5:0] sb;
    sb = 6'(bank);
    if (bank >= 64) sb = sb & 6'((1 << DEV1) - 1);
    return {sb, a[12:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ioWrite(logic [7:0] off);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = {8'hD5, off};
    @(posedge clk);
    #1 busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic otherCycle(logic [15:0] a, logic wr);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a;
    @(posedge clk);
    #1 busValid = 1'b0; busWrite = 1'b0;
  endtask

  // drive one window access and sample combinational outputs mid-phase
  task automatic probe(string req, logic [15:0] a, logic wr,
                       logic [1:0] eSel, logic [1:0] eWe, logic [18:0] eMem);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a;
    #1;
    check(req, 32'(chipSel), 32'(eSel));
    check(req, 32'(chipWe), 32'(eWe));
    if (eSel != 2'b00) check(req, 32'(memAddr), 32'(eMem));
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic tReset();
    check("R1 absent", 32'(cartAbsent), 0);
    probe("R1", 16'hA123, 1'b0, 2'b01, 2'b00, expMem(0, 16'hA123));
  endtask

  task automatic tSelect();
    ioWrite(8'h01);
    probe("R2 bank1", 16'hA000, 1'b0, 2'b01, 2'b00, expMem(1, 16'hA000));
    ioWrite(8'h25);
    probe("R2 bank37", 16'hBFFF, 1'b0, 2'b01, 2'b00, expMem(37, 16'hBFFF));
    ioWrite(8'h3F);
    probe("R5 bank63", 16'hA555, 1'b0, 2'b01, 2'b00, expMem(63, 16'hA555));
  endtask

  task automatic tSocket2();
    ioWrite(8'h40);
    probe("R5 bank64", 16'hA010, 1'b0, 2'b10, 2'b00, expMem(64, 16'hA010));
    ioWrite(8'h7F);
    probe("R5 bank127", 16'hB00F, 1'b0, 2'b10, 2'b00, expMem(127, 16'hB00F));
    ioWrite(8'h60);
    probe("R6 alias96", 16'hA777, 1'b0, 2'b10, 2'b00, 19'({6'd0, 13'h0777}));
    probe("R5 outside", 16'hC000, 1'b0, 2'b00, 2'b00, 19'd0);
    probe("R5 below", 16'h9FFF, 1'b0, 2'b00, 2'b00, 19'd0);
  endtask

  task automatic tWrite();
    ioWrite(8'h05);
    wrProtect = 1'b0;
    probe("R7 we0", 16'hA002, 1'b1, 2'b01, 2'b01, expMem(5, 16'hA002));
    wrProtect = 1'b1;
    probe("R7 prot0", 16'hA002, 1'b1, 2'b01, 2'b00, expMem(5, 16'hA002));
    ioWrite(8'h45);
    probe("R7 we1 prot", 16'hA002, 1'b1, 2'b10, 2'b10, expMem(69, 16'hA002));
    wrProtect = 1'b0;
  endtask

  task automatic tDisable();
    ioWrite(8'h80);
    #1 check("R3 absent", 32'(cartAbsent), 1);
    probe("R3 noSel", 16'hA000, 1'b1, 2'b00, 2'b00, 19'd0);
    ioWrite(8'h12);
    #1 check("R4 present", 32'(cartAbsent), 0);
    probe("R4 bank18", 16'hA100, 1'b0, 2'b01, 2'b00, expMem(18, 16'hA100));
  endtask

  task automatic tIgnored();
    ioWrite(8'h81);
    ioWrite(8'hFF);
    otherCycle(16'hD505, 1'b0);
    otherCycle(16'hD433, 1'b1);
    otherCycle(16'hD680, 1'b1);
    #1 check("R8 present", 32'(cartAbsent), 0);
    probe("R8 keep18", 16'hA100, 1'b0, 2'b01, 2'b00, expMem(18, 16'hA100));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tSelect();
    tSocket2();
    tWrite();
    tDisable();
    tIgnored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule